// File: doc/BRIEF.md
# Asynchronous FIFO Burst Reader

This block sits on the host side of an asynchronous 16-bit parallel bus and drains a receive data FIFO in bursts. A request names a word count and a byte-order setting. The block then asserts the active-low chip select and read strobe together, raises the FIFO select line and keeps the strobes low until the burst ends. Each further word is fetched by flipping the low bit of the two-bit word address. A capture is taken only after the bus data is guaranteed valid. Every captured word leaves on a valid/ready stream.

All bus timing is held as picosecond parameters. These are turned into whole clock cycles, rounded up, against a clock-period parameter. If the downstream stream is not ready, the block waits before the next address flip and keeps the strobes low, so no word is dropped. After the last word is delivered and the strobes are high again, a one-cycle done pulse is raised.

Top module: `pio_burst_rd`

## Requirements
- R1: After reset, both strobes are high, FIFO select is low, `word_valid_o` and `done_o` are low, and `req_ready_o` is high.
- R2: `req_len_i` holds the word count minus one (0 means 1 word, 255 means 256 words). On the cycle after a request is accepted, both strobes are low, FIFO select is high and `bus_addr_o` is 2'b00.
- R3: The first word of a burst is captured no earlier than the larger of 30 ns and 40 ns after the strobes go low, rounded up to whole cycles.
- R4: Each later word comes from a flip of `bus_addr_o[0]` while the strobes stay low. Successive flips, and the first flip after the strobes go low, are at least 45 ns apart.
- R5: Every word after the first is captured no earlier than 40 ns after its address flip.
- R6: Words leave in bus order on the valid/ready stream. A word that is not accepted keeps its data, and valid stays high.
- R7: While a delivered word is waiting on `word_ready_i`, the address does not change and the strobes stay low.
- R8: A burst yields exactly the requested number of words. The strobes go high on the same edge that captures the last word.
- R9: `done_o` is a single-cycle pulse. It follows the acceptance of the last word and arrives with the strobes high and `word_valid_o` low.
- R10: Between bursts, the strobes stay high for at least the larger of 13 ns and 9 ns. `req_ready_o` is low from acceptance until the burst is done.
- R11: `bus_endian_o` follows the request's endian bit, and it and `bus_addr_o[1]` (always 0) hold steady while the strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Burst request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_len_i | input | 8 | Word count minus one |
| req_endian_i | input | 1 | Byte-order setting for the burst |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_rd_no | output | 1 | Read strobe, active low |
| bus_addr_o | output | 2 | Word address; bit 0 flips per word |
| bus_fifo_sel_o | output | 1 | Selects the receive data FIFO |
| bus_endian_o | output | 1 | Byte-order select on the bus |
| bus_data_i | input | 16 | Bus read data |
| word_valid_o | output | 1 | Captured word available |
| word_ready_i | input | 1 | Downstream takes the word |
| word_data_o | output | 16 | Captured word |
| done_o | output | 1 | Burst finished pulse |

## Verification
The assertions assume the device meets its stated access times, so data sampled at the counted edges is valid. They also assume `word_ready_i` and `req_valid_i` change only between clock edges. The bench device model drives a marker value after each strobe fall or address flip and presents the real FIFO word 1 ns before the guaranteed delay. A capture taken even one cycle early therefore shows up as a data mismatch. Ready is driven at the falling edge, either randomly or held low for long stalls, and requests are issued only from the falling edge.

// File: rtl/pio_burst_pkg.sv
`timescale 1ns/1ps
package pio_burst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_HOLD,
    ST_STEP,
    ST_DRAIN
  } rd_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // ps -> cycles, rounded up, never below one
  function automatic int unsigned cyc_of(input int unsigned ps, input int unsigned period_ps);
    return max2((ps + period_ps - 1) / period_ps, 1);
  endfunction

endpackage

// File: rtl/pio_dly_cnt.sv
`timescale 1ns/1ps
module pio_dly_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pio_word_out.sv
`timescale 1ns/1ps
module pio_word_out #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] cap_data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              free_o
);

  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (cap_i) begin
      valid_q <= 1'b1;
      data_q  <= cap_data_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign free_o  = !valid_q || ready_i;

endmodule

// File: rtl/pio_burst_rd.sv
`timescale 1ns/1ps
module pio_burst_rd
  import pio_burst_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned T_CSDV_PS     = 30000,
  parameter int unsigned T_ADV_PS      = 40000,
  parameter int unsigned T_ACYC_PS     = 45000,
  parameter int unsigned T_CSH_PS      = 13000,
  parameter int unsigned T_DOFF_PS     = 9000,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned LEN_W         = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_endian_i,
  output logic              bus_cs_no,
  output logic              bus_rd_no,
  output logic [1:0]        bus_addr_o,
  output logic              bus_fifo_sel_o,
  output logic              bus_endian_o,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              word_valid_o,
  input  logic              word_ready_i,
  output logic [DATA_W-1:0] word_data_o,
  output logic              done_o
);

  localparam int unsigned FIRST_CYC = max2(cyc_of(T_CSDV_PS, CLK_PERIOD_PS),
                                           cyc_of(T_ADV_PS, CLK_PERIOD_PS));
  localparam int unsigned ADV_CYC   = cyc_of(T_ADV_PS, CLK_PERIOD_PS);
  localparam int unsigned ACYC_CYC  = cyc_of(T_ACYC_PS, CLK_PERIOD_PS);
  localparam int unsigned GAP_CYC   = max2(cyc_of(T_CSH_PS, CLK_PERIOD_PS),
                                           cyc_of(T_DOFF_PS, CLK_PERIOD_PS));
  localparam int unsigned CNT_MAX   = max2(max2(FIRST_CYC, ADV_CYC), max2(ACYC_CYC, GAP_CYC));
  localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);
  localparam int unsigned LEFT_W    = LEN_W + 1;

  rd_state_e         state_q;
  logic              strobe_q;
  logic [1:0]        addr_q;
  logic              endian_q;
  logic [LEFT_W-1:0] left_q;
  logic              done_q;

  logic wait_zero, acyc_zero, gap_zero, out_free;
  logic accept, capture, toggle, last;

  assign req_ready_o = (state_q == ST_IDLE) && gap_zero;
  assign accept      = req_ready_o && req_valid_i;
  assign capture     = ((state_q == ST_FIRST) || (state_q == ST_STEP)) && wait_zero;
  assign last        = (left_q == LEFT_W'(1));
  assign toggle      = (state_q == ST_HOLD) && acyc_zero && out_free;

  // data-valid wait: first word or after each address flip
  pio_dly_cnt #(.W(CNT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept || toggle),
    .load_val_i (accept ? CNT_W'(FIRST_CYC - 1) : CNT_W'(ADV_CYC - 1)),
    .zero_o     (wait_zero)
  );

  // minimum spacing between address changes
  pio_dly_cnt #(.W(CNT_W)) u_acyc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept || toggle),
    .load_val_i (CNT_W'(ACYC_CYC - 1)),
    .zero_o     (acyc_zero)
  );

  // strobe-high time and bus release before the next access
  pio_dly_cnt #(.W(CNT_W)) u_gap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (capture && last),
    .load_val_i (CNT_W'(GAP_CYC - 1)),
    .zero_o     (gap_zero)
  );

  pio_word_out #(.DATA_W(DATA_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (capture),
    .cap_data_i (bus_data_i),
    .ready_i    (word_ready_i),
    .valid_o    (word_valid_o),
    .data_o     (word_data_o),
    .free_o     (out_free)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      strobe_q <= 1'b0;
      addr_q   <= 2'b00;
      endian_q <= 1'b0;
      left_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          strobe_q <= 1'b1;
          addr_q   <= 2'b00;
          endian_q <= req_endian_i;
          left_q   <= {1'b0, req_len_i} + LEFT_W'(1);
          state_q  <= ST_FIRST;
        end
        ST_FIRST, ST_STEP: if (capture) begin
          left_q <= left_q - LEFT_W'(1);
          if (last) begin
            strobe_q <= 1'b0;
            state_q  <= ST_DRAIN;
          end else begin
            state_q  <= ST_HOLD;
          end
        end
        ST_HOLD: if (toggle) begin
          addr_q[0] <= ~addr_q[0];
          state_q   <= ST_STEP;
        end
        ST_DRAIN: if (word_valid_o && word_ready_i) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_cs_no      = !strobe_q;
  assign bus_rd_no      = !strobe_q;
  assign bus_fifo_sel_o = strobe_q;
  assign bus_addr_o     = addr_q;
  assign bus_endian_o   = endian_q;
  assign done_o         = done_q;

endmodule

// File: rtl/pio_burst_rd_chk.sv
`timescale 1ns/1ps
module pio_burst_rd_chk
  import pio_burst_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned T_ACYC_PS     = 45000,
  parameter int unsigned T_CSH_PS      = 13000,
  parameter int unsigned T_DOFF_PS     = 9000,
  parameter int unsigned DATA_W        = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              bus_cs_no,
  input logic [1:0]        bus_addr_o,
  input logic              bus_endian_o,
  input logic              word_valid_o,
  input logic              word_ready_i,
  input logic [DATA_W-1:0] word_data_o,
  input logic              done_o
);

  localparam int unsigned ACYC_CYC = cyc_of(T_ACYC_PS, CLK_PERIOD_PS);
  localparam int unsigned GAP_CYC  = max2(cyc_of(T_CSH_PS, CLK_PERIOD_PS),
                                          cyc_of(T_DOFF_PS, CLK_PERIOD_PS));
  localparam int unsigned SAT      = 32'h0000_FFFF;

  int unsigned since_addr;
  int unsigned hi_run;
  logic [1:0]  addr_q;
  logic        cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_addr <= SAT;
      hi_run     <= SAT;
      addr_q     <= 2'b00;
      cs_q       <= 1'b1;
    end else begin
      addr_q     <= bus_addr_o;
      cs_q       <= bus_cs_no;
      since_addr <= (bus_addr_o != addr_q) ? 1 : ((since_addr >= SAT) ? SAT : since_addr + 1);
      hi_run     <= bus_cs_no ? ((hi_run >= SAT) ? SAT : hi_run + 1) : 0;
    end
  end

  // R2
  accept_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !bus_cs_no && (bus_addr_o == 2'b00));

  // R4
  addr_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_cs_no && !cs_q && (bus_addr_o != addr_q)) |-> (since_addr >= ACYC_CYC));

  // R6
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_data_o));

  // R7
  stall_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i && !bus_cs_no |=> $stable(bus_addr_o) && !bus_cs_no);

  // R9
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> bus_cs_no && !word_valid_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  strobe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_cs_no && cs_q) |-> (hi_run >= GAP_CYC));

  // R11
  side_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_cs_no && !cs_q) |-> $stable(bus_endian_o) && (bus_addr_o[1] == 1'b0));

endmodule

bind pio_burst_rd pio_burst_rd_chk #(
  .CLK_PERIOD_PS (CLK_PERIOD_PS),
  .T_ACYC_PS     (T_ACYC_PS),
  .T_CSH_PS      (T_CSH_PS),
  .T_DOFF_PS     (T_DOFF_PS),
  .DATA_W        (DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .bus_cs_no    (bus_cs_no),
  .bus_addr_o   (bus_addr_o),
  .bus_endian_o (bus_endian_o),
  .word_valid_o (word_valid_o),
  .word_ready_i (word_ready_i),
  .word_data_o  (word_data_o),
  .done_o       (done_o)
);

// File: tb/sim_pio_burst_rd.sv
`timescale 1ns/1ps
module sim_pio_burst_rd;

  localparam logic [15:0] JUNK   = 16'hDEAD;
  localparam int          MEM_N  = 2048;
  localparam real         T_FIRST_NS = 39.0;  // device faster than the guaranteed 40 ns
  localparam real         T_ADV_NS   = 39.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_len = 8'd0;
  logic        req_endian = 1'b0;
  logic        bus_cs_n, bus_rd_n, bus_fifo_sel, bus_endian;
  logic [1:0]  bus_addr;
  logic [15:0] dev_data = JUNK;
  logic        word_valid;
  logic        word_ready = 1'b0;
  logic [15:0] word_data;
  logic        done;

  always #2 clk = ~clk;

  pio_burst_rd u0 (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .req_valid_i    (req_valid),
    .req_ready_o    (req_ready),
    .req_len_i      (req_len),
    .req_endian_i   (req_endian),
    .bus_cs_no      (bus_cs_n),
    .bus_rd_no      (bus_rd_n),
    .bus_addr_o     (bus_addr),
    .bus_fifo_sel_o (bus_fifo_sel),
    .bus_endian_o   (bus_endian),
    .bus_data_i     (dev_data),
    .word_valid_o   (word_valid),
    .word_ready_i   (word_ready),
    .word_data_o    (word_data),
    .done_o         (done)
  );

  logic [15:0] mem [0:MEM_N-1];
  int  rd_ptr = 0, exp_idx = 0, gen = 0;
  int  n_chk = 0, n_err = 0;
  int  got = 0, exp_len = 0, ready_mode = 0;
  bit  run = 0, done_seen = 0, done_prev = 0, finished = 0;
  bit  act_now, act_q = 0;
  logic a_q = 1'b0;
  real t_addr = 0.0, t_rel = -1000.0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic dev_present(input int g, input real dly);
    #(dly);
    if (g == gen) dev_data = mem[rd_ptr % MEM_N];
  endtask

  // device model and bus timing monitor
  always @(bus_cs_n or bus_rd_n or bus_addr) begin
    act_now = !bus_cs_n && !bus_rd_n;
    if (act_now && !act_q) begin
      if (run) chk(($realtime - t_rel) >= 12.999, "R10", "strobe high time ns",
                   longint'($realtime - t_rel), 13);
      t_addr = $realtime;
      gen++;
      dev_data = JUNK;
      fork dev_present(gen, T_FIRST_NS); join_none
    end else if (act_now && (bus_addr[0] != a_q)) begin
      chk(($realtime - t_addr) >= 44.999, "R4", "address flip spacing ns",
          longint'($realtime - t_addr), 45);
      t_addr = $realtime;
      rd_ptr++;
      gen++;
      dev_data = JUNK;
      fork dev_present(gen, T_ADV_NS); join_none
    end else if (!act_now && act_q) begin
      t_rel = $realtime;
      rd_ptr++;
      gen++;
      dev_data = JUNK;
    end
    act_q = act_now;
    a_q   = bus_addr[0];
  end

  // stream consumer, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && run) begin
      chk(bus_cs_n == bus_rd_n, "R2", "strobes differ", bus_cs_n, bus_rd_n);
      case (ready_mode)
        0:       word_ready = 1'b1;
        1:       word_ready = ($urandom % 4) != 0;
        default: word_ready = 1'b0;
      endcase
      if (word_valid && word_ready) begin
        chk(word_data == mem[exp_idx % MEM_N], (got == 0) ? "R3" : "R5",
            "word data", word_data, mem[exp_idx % MEM_N]);
        exp_idx++;
        got++;
      end
      if (done) begin
        chk(got == exp_len, "R8", "words per burst", got, exp_len);
        chk(bus_cs_n && !word_valid, "R9", "done with strobes high", bus_cs_n, 1);
        chk(!done_prev, "R9", "done pulse width", done_prev, 0);
        done_seen = 1;
      end
      done_prev = done;
    end
  end

  task automatic start_burst(input int len, input bit endian);
    got = 0; exp_len = len; done_seen = 0;
    req_len = 8'(len - 1); req_endian = endian; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!bus_cs_n && bus_fifo_sel && (bus_addr == 2'b00), "R2", "burst start bus state",
        {bus_cs_n, bus_fifo_sel, bus_addr}, 4'b0100);
    chk(bus_endian == endian, "R11", "endian select", bus_endian, endian);
    chk(!req_ready, "R10", "busy during burst", req_ready, 0);
  endtask

  task automatic wait_done();
    while (!done_seen) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = 16'($urandom);
      if (mem[i] == JUNK) mem[i] = 16'h1234;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_cs_n && bus_rd_n && !bus_fifo_sel, "R1", "strobes after reset",
        {bus_cs_n, bus_rd_n, bus_fifo_sel}, 3'b110);
    chk(!word_valid && !done && req_ready, "R1", "outputs after reset",
        {word_valid, done, req_ready}, 3'b001);
    run = 1;

    // directed: shortest and longest bursts, back to back
    ready_mode = 0;
    start_burst(1, 1'b0);   wait_done();
    start_burst(256, 1'b1); wait_done();
    start_burst(2, 1'b0);   wait_done();

    // directed: long stall with the first word waiting
    begin
      bit ok;
      logic [1:0] a0;
      ok = 1;
      ready_mode = 2;
      start_burst(4, 1'b1);
      while (!word_valid) @(negedge clk);
      a0 = bus_addr;
      repeat (30) begin
        @(negedge clk);
        ok &= (bus_addr == a0) && !bus_cs_n && word_valid;
      end
      chk(ok, "R7", "stall holds address and strobes", ok, 1);
      ready_mode = 0;
      wait_done();
    end

    // random bursts with random back-pressure
    ready_mode = 1;
    for (int b = 0; b < 24; b++) begin
      start_burst(1 + int'($urandom % 40), 1'($urandom));
      wait_done();
      if ($urandom % 2) repeat ($urandom % 5) @(negedge clk);
    end
    ready_mode = 0;
    repeat (10) @(negedge clk);
    chk(bus_cs_n && !word_valid, "R8", "idle after last burst", bus_cs_n, 1);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #600000;
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

endmodule